// File: doc/BRIEF.md
# Dual-Register NCO Phase Core

This block is the digital heart of a direct digital synthesizer. A 28-bit phase accumulator advances every clock by a frequency word taken from one of two frequency registers, so the output rate is that word as a fraction of the clock rate. One of two 12-bit phase-offset registers is added to the top 12 bits of the accumulator output, not to its input. The result, registered, is the address for an external sine table. Its most significant bit can also drive a square-wave sign output.

Each register pair is selected either by an external pin or by a bit in the control register. A mode bit in the control register chooses between pins and bits. A parallel load port writes the registers. An active-high clear input zeroes only the accumulation path and leaves every programmed register as it was. A sleep input or sleep control bit silences the outputs. The sign output is gated by an enable bit and can carry either the phase MSB or an external comparator bit.

Top module: `nco_phase_core`

## Requirements
- R1: While `rst_n` is low, the accumulator, all frequency, phase and control registers, `sine_addr` and `sign_out` are all zero.
- R2: On each clock without clear, the accumulator adds the selected 28-bit frequency word modulo 2^28. On the same edge `sine_addr` is loaded with (accumulator[27:16] + selected phase word) mod 4096, using the accumulator value from before that edge.
- R3: If control bit 2 is 1, `fsel_pin` selects the frequency register. If it is 0, control bit 0 selects it. A value of 0 selects frequency register 0 and 1 selects frequency register 1.
- R4: Under the same mode bit 2, `psel_pin` or control bit 1 selects phase register 0 (value 0) or phase register 1 (value 1).
- R5: The phase offset changes only the address. Removing an offset brings `sine_addr` back to the trajectory it would have had without the offset.
- R6: `wr_sel` codes are 0 = frequency 0, 1 = frequency 1, 2 = phase 0 (`wr_data[11:0]`), 3 = phase 1 (`wr_data[11:0]`) and 4 = control (`wr_data[5:0]`). A write with `wr_en` high is stored at the clock edge and is used from the next edge. Registers without a write hold their value. Changing the frequency select keeps the accumulator value, so phase stays continuous.
- R7: While `acc_clr` is high, each edge sets the accumulator, `sine_addr` and `sign_out` to 0. Programmed registers are kept, and a write in the same cycle still lands.
- R8: If `sleep_pin` is high or control bit 3 is 1, each edge sets `sine_addr` to 0 (the midscale-amplitude address) and `sign_out` to 0. The accumulator keeps running.
- R9: If control bit 4 is 0, `sign_out` is loaded with 0. If it is 1 and control bit 5 is 1, `sign_out` is loaded with `cmp_in`. If it is 1 and control bit 5 is 0, `sign_out` is loaded with bit 11 of the offset-adjusted phase. All of these are registered, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| acc_clr | input | 1 | Active-high synchronous clear of the accumulation path |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 28 | Write data |
| fsel_pin | input | 1 | External frequency register select |
| psel_pin | input | 1 | External phase register select |
| sleep_pin | input | 1 | External sleep request |
| cmp_in | input | 1 | External comparator bit |
| sine_addr | output | 12 | Registered sine table address |
| sign_out | output | 1 | Gated sign or comparator output |

## Verification
Two functions can fall in the same cycle: an accumulation clear and a register write. The bench provokes this with directed cycles that raise `acc_clr` together with a frequency or control write. It also lets random stimulus drive clear, sleep and writes at once. A cycle-accurate reference model in the bench judges the result. It expects the accumulator and outputs to go to zero while the written value takes effect on the following edge. Select changes in the same cycle as a write are covered the same way.

// File: rtl/nco_pkg.sv
package nco_pkg;
   typedef enum logic [2:0] {
      WSEL_FREQ0  = 3'd0,
      WSEL_FREQ1  = 3'd1,
      WSEL_PHASE0 = 3'd2,
      WSEL_PHASE1 = 3'd3,
      WSEL_CTRL   = 3'd4
   } wsel_e;

   localparam int CTRL_W         = 6;
   localparam int CB_FSEL        = 0;
   localparam int CB_PSEL        = 1;
   localparam int CB_PIN_MODE    = 2;
   localparam int CB_SLEEP       = 3;
   localparam int CB_SIGN_EN     = 4;
   localparam int CB_SIGN_CMP    = 5;
   localparam int NUM_BANK       = 2;
endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
   import nco_pkg::*;
#(
   parameter int ACC_W = 28,
   parameter int PH_W  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_sel,
   input  logic [ACC_W-1:0]     wr_data,
   output logic [ACC_W-1:0]     freq_q  [NUM_BANK],
   output logic [PH_W-1:0]      phase_q [NUM_BANK],
   output logic [CTRL_W-1:0]    ctrl_q
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANK; gi++) begin : g_bank
         localparam logic [2:0] FCODE = 3'(WSEL_FREQ0) + 3'(gi);
         localparam logic [2:0] PCODE = 3'(WSEL_PHASE0) + 3'(gi);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               freq_q[gi]  <= '0;
               phase_q[gi] <= '0;
            end else if (wr_en) begin
               if (wr_sel == FCODE) freq_q[gi]  <= wr_data;
               if (wr_sel == PCODE) phase_q[gi] <= wr_data[PH_W-1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctrl_q <= '0;
      else if (wr_en && wr_sel == WSEL_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
   end

   // R6
   hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(freq_q[0]) && $stable(freq_q[1]) &&
                 $stable(phase_q[0]) && $stable(phase_q[1]) && $stable(ctrl_q));
endmodule

// File: rtl/nco_select.sv
module nco_select
   import nco_pkg::*;
#(
   parameter int ACC_W = 28,
   parameter int PH_W  = 12
) (
   input  logic [ACC_W-1:0]  freq_q  [NUM_BANK],
   input  logic [PH_W-1:0]   phase_q [NUM_BANK],
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic              fsel_pin,
   input  logic              psel_pin,
   input  logic              sleep_pin,
   output logic [ACC_W-1:0]  freq_sel,
   output logic [PH_W-1:0]   phase_sel,
   output logic              sleep_eff,
   output logic              sign_en,
   output logic              sign_cmp
);
   logic fs, ps;
   always_comb begin
      fs        = ctrl_q[CB_PIN_MODE] ? fsel_pin : ctrl_q[CB_FSEL];
      ps        = ctrl_q[CB_PIN_MODE] ? psel_pin : ctrl_q[CB_PSEL];
      freq_sel  = fs ? freq_q[1]  : freq_q[0];
      phase_sel = ps ? phase_q[1] : phase_q[0];
      sleep_eff = sleep_pin | ctrl_q[CB_SLEEP];
      sign_en   = ctrl_q[CB_SIGN_EN];
      sign_cmp  = ctrl_q[CB_SIGN_CMP];
   end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int ACC_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_clr,
   input  logic [ACC_W-1:0] freq_sel,
   output logic [ACC_W-1:0] acc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (acc_clr) acc_q <= '0;
      else              acc_q <= acc_q + freq_sel;
   end

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> acc_q == '0);
endmodule

// File: rtl/nco_outstage.sv
module nco_outstage #(
   parameter int ACC_W  = 28,
   parameter int PH_W   = 12,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_clr,
   input  logic [ACC_W-1:0]  acc_q,
   input  logic [PH_W-1:0]   phase_sel,
   input  logic              sleep_eff,
   input  logic              sign_en,
   input  logic              sign_cmp,
   input  logic              cmp_in,
   output logic [ADDR_W-1:0] sine_addr,
   output logic              sign_out
);
   localparam int TOP_LSB = ACC_W - PH_W;
   logic [PH_W-1:0] phase_sum;
   logic            sign_d;

   always_comb begin
      phase_sum = acc_q[ACC_W-1:TOP_LSB] + phase_sel;
      if (sleep_eff || !sign_en) sign_d = 1'b0;
      else if (sign_cmp)         sign_d = cmp_in;
      else                       sign_d = phase_sum[PH_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sine_addr <= '0;
         sign_out  <= 1'b0;
      end else if (acc_clr) begin
         sine_addr <= '0;
         sign_out  <= 1'b0;
      end else begin
         sine_addr <= sleep_eff ? '0 : phase_sum[PH_W-1 -: ADDR_W];
         sign_out  <= sign_d;
      end
   end

   // R8
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_eff |=> sine_addr == '0 && !sign_out);
   // R9
   sign_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sign_en |=> !sign_out);
   // R9
   sign_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr && !sleep_eff && sign_en && sign_cmp) |=> sign_out == $past(cmp_in));
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
   import nco_pkg::*;
#(
   parameter int ACC_W  = 28,
   parameter int PH_W   = 12,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_clr,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              fsel_pin,
   input  logic              psel_pin,
   input  logic              sleep_pin,
   input  logic              cmp_in,
   output logic [ADDR_W-1:0] sine_addr,
   output logic              sign_out
);
   generate
      if (PH_W > ACC_W) begin : g_bad_ph
         $error("phase width exceeds accumulator width");
      end
      if (ADDR_W > PH_W) begin : g_bad_addr
         $error("address width exceeds phase width");
      end
      if (ACC_W < CTRL_W) begin : g_bad_ctrl
         $error("write port too narrow for control word");
      end
   endgenerate

   logic [ACC_W-1:0]  freq_q  [NUM_BANK];
   logic [PH_W-1:0]   phase_q [NUM_BANK];
   logic [CTRL_W-1:0] ctrl_q;
   logic [ACC_W-1:0]  freq_sel;
   logic [PH_W-1:0]   phase_sel;
   logic [ACC_W-1:0]  acc_q;
   logic              sleep_eff, sign_en, sign_cmp;

   nco_regbank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .freq_q(freq_q), .phase_q(phase_q), .ctrl_q(ctrl_q));

   nco_select #(.ACC_W(ACC_W), .PH_W(PH_W)) u_sel (
      .freq_q(freq_q), .phase_q(phase_q), .ctrl_q(ctrl_q),
      .fsel_pin(fsel_pin), .psel_pin(psel_pin), .sleep_pin(sleep_pin),
      .freq_sel(freq_sel), .phase_sel(phase_sel), .sleep_eff(sleep_eff),
      .sign_en(sign_en), .sign_cmp(sign_cmp));

   nco_accum #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .freq_sel(freq_sel), .acc_q(acc_q));

   nco_outstage #(.ACC_W(ACC_W), .PH_W(PH_W), .ADDR_W(ADDR_W)) u_out (
      .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .acc_q(acc_q), .phase_sel(phase_sel),
      .sleep_eff(sleep_eff), .sign_en(sign_en), .sign_cmp(sign_cmp), .cmp_in(cmp_in),
      .sine_addr(sine_addr), .sign_out(sign_out));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> sine_addr == '0 && !sign_out);
endmodule

// File: tb/nco_phase_core_bench.sv
module nco_phase_core_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_clr = 1'b0, wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [27:0] wr_data = '0;
   logic        fsel_pin = 1'b0, psel_pin = 1'b0, sleep_pin = 1'b0, cmp_in = 1'b0;
   logic [11:0] sine_addr;
   logic        sign_out;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_phase_core u_nco_phase_core (
      .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .fsel_pin(fsel_pin), .psel_pin(psel_pin), .sleep_pin(sleep_pin),
      .cmp_in(cmp_in), .sine_addr(sine_addr), .sign_out(sign_out));

   // reference model built from the requirements
   logic [27:0] m_f0, m_f1, m_acc;
   logic [11:0] m_p0, m_p1, m_addr;
   logic [5:0]  m_c;
   logic        m_sign;

   function automatic logic [11:0] exp_sum(logic [27:0] a, logic [11:0] p);
      return a[27:16] + p;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_f0 <= '0; m_f1 <= '0; m_p0 <= '0; m_p1 <= '0; m_c <= '0;
         m_acc <= '0; m_addr <= '0; m_sign <= 1'b0;
      end else begin
         logic fs, ps, sl;
         logic [11:0] s;
         fs = m_c[2] ? fsel_pin : m_c[0];
         ps = m_c[2] ? psel_pin : m_c[1];
         sl = sleep_pin | m_c[3];
         s  = exp_sum(m_acc, ps ? m_p1 : m_p0);
         if (acc_clr) begin
            m_acc <= '0; m_addr <= '0; m_sign <= 1'b0;
         end else begin
            m_acc  <= m_acc + (fs ? m_f1 : m_f0);
            m_addr <= sl ? 12'd0 : s;
            m_sign <= (sl || !m_c[4]) ? 1'b0 : (m_c[5] ? cmp_in : s[11]);
         end
         if (wr_en) begin
            case (wr_sel)
               3'd0: m_f0 <= wr_data;
               3'd1: m_f1 <= wr_data;
               3'd2: m_p0 <= wr_data[11:0];
               3'd3: m_p1 <= wr_data[11:0];
               3'd4: m_c  <= wr_data[5:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check_now();
      n_chk++;
      if (sine_addr !== m_addr || sign_out !== m_sign) begin
         n_fail++;
         $display("FAIL %s: addr=%0h sign=%0b expected addr=%0h sign=%0b",
                  cur_req, sine_addr, sign_out, m_addr, m_sign);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_now();
         wr_en = 1'b0; acc_clr = 1'b0;
      end
   endtask

   task automatic wr(logic [2:0] s, logic [27:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      step(1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check_now();
      rst_n = 1'b1;
      step(2);
      // R2 basic accumulation
      cur_req = "R2";
      wr(3'd0, 28'h0123457);
      wr(3'd1, 28'h0F00001);
      wr(3'd4, 28'h10);
      step(40);
      wr(3'd0, 28'hFFFFFFF);
      step(20);
      // R3 frequency select by bit then pin
      cur_req = "R3";
      wr(3'd4, 28'h11);
      step(15);
      wr(3'd4, 28'h14);
      for (int i = 0; i < 60; i++) begin
         fsel_pin = 1'($urandom);
         step(1);
      end
      // R4 phase select
      cur_req = "R4";
      wr(3'd2, 28'h100);
      wr(3'd3, 28'hA55);
      for (int i = 0; i < 60; i++) begin
         psel_pin = 1'($urandom);
         step(1);
      end
      wr(3'd4, 28'h12);
      step(10);
      // R5 offset returns to base trajectory
      cur_req = "R5";
      wr(3'd3, 28'h7FF);
      step(10);
      wr(3'd3, 28'h0);
      wr(3'd2, 28'h0);
      step(10);
      // R6 writes and continuity across select change
      cur_req = "R6";
      wr(3'd0, 28'h0000100);
      wr(3'd1, 28'h0400000);
      wr(3'd4, 28'h10);
      step(5);
      wr(3'd4, 28'h11);
      step(5);
      wr(3'd5, 28'hFFFFFFF);
      step(5);
      // R7 clear, including clear with same-cycle write
      cur_req = "R7";
      acc_clr = 1'b1;
      step(1);
      step(8);
      acc_clr = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 28'h0123456;
      step(1);
      step(8);
      acc_clr = 1'b1; wr_en = 1'b1; wr_sel = 3'd4; wr_data = 28'h10;
      step(1);
      step(8);
      // R8 sleep via pin and bit
      cur_req = "R8";
      sleep_pin = 1'b1;
      step(10);
      sleep_pin = 1'b0;
      step(5);
      wr(3'd4, 28'h18);
      step(10);
      wr(3'd4, 28'h10);
      step(5);
      // R9 sign output modes
      cur_req = "R9";
      for (int m = 0; m < 4; m++) begin
         wr(3'd4, {22'd0, 1'(m >> 1), 1'(m), 4'd0});
         for (int i = 0; i < 30; i++) begin
            cmp_in = 1'($urandom);
            step(1);
         end
      end
      // mixed random traffic
      cur_req = "R2/R7/R8 mixed";
      for (int i = 0; i < 3000; i++) begin
         fsel_pin  = 1'($urandom);
         psel_pin  = 1'($urandom);
         cmp_in    = 1'($urandom);
         sleep_pin = ($urandom % 16) == 0;
         acc_clr   = ($urandom % 32) == 0;
         wr_en     = ($urandom % 6) == 0;
         wr_sel    = 3'($urandom % 5);
         wr_data   = 28'($urandom);
         if (wr_sel == 3'd4) wr_data[3] = ($urandom % 4) == 0;
         @(negedge clk);
         check_now();
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule